// File: doc/BRIEF.md
# Eight-Channel Byte Mover

The block moves single bytes between a wide memory side and a narrow peripheral side for up to eight independent channels. The memory side uses a 24-bit address made of an 8-bit bank and a 16-bit offset. The peripheral side uses an 8-bit register address. Software fills each channel's registers through a byte-wide register port and then writes a channel bitmask to a start strobe. The engine then works through the flagged channels from the lowest index upward. Each channel runs to completion before the next one begins.

For every byte, the engine makes one read and one write, in an order set by the channel's direction bit. The peripheral address is the channel's base register plus a small offset. That offset follows a repeating four-step pattern chosen by the channel's mode. After each byte, the memory offset holds, steps down or steps up, and the 16-bit byte counter decreases by one. Some memory-side targets are illegal. These are filtered quietly: the write is not issued, and a read takes the `open_bus` value instead of making a bus request.

A single state machine controls the transfer. Its states are `ST_IDLE`, `ST_A_READ`, `ST_B_WRITE`, `ST_B_READ`, `ST_A_WRITE` and `ST_STEP`. Its transitions are as follows:
- **`ST_IDLE` → first phase:** taken when any channel is active. The state machine latches the lowest active channel and goes to `ST_A_READ` for memory-to-peripheral transfers or to `ST_B_READ` for peripheral-to-memory transfers.
- **Read phase → write phase:** `ST_A_READ` → `ST_B_WRITE` and `ST_B_READ` → `ST_A_WRITE`. These advance on `*_ready`, or at once when the memory access is filtered.
- **Write phase → `ST_STEP`:** taken on `*_ready`, or at once when the memory write is suppressed.
- **`ST_STEP` → next:** if the decremented counter is zero, the channel is cleared and the state machine returns to `ST_IDLE`. Otherwise it goes back to the channel's read phase.

Top module: `dma8_engine`

## Requirements
- R1: Register select bits [6:4] choose the channel and bits [3:0] choose the field. Field offsets are:
  - 0: control
  - 1: memory bank
  - 2: memory offset low byte
  - 3: memory offset high byte
  - 4: count low byte
  - 5: count high byte
  - 6: peripheral base
  - 7: spare bank
  - 8: table low byte
  - 9: table high byte
  - 10: line counter
  - 11: spare byte

  Every field reads back the value last written to it. Offsets 12 to 15 read 0xFF.
- R2: After reset, the control byte reads 0xF8 and every other byte field reads 0xFF. No channel is active.
- R3: The control byte fields are:
  - [2:0]: mode
  - bit 3: hold the memory offset
  - bit 4: step the offset down
  - bit 5: spare storage bit
  - bit 6: indirect flag (stored only)
  - bit 7: direction, peripheral-to-memory when set

  All eight bits read back.
- R4: A start strobe while `busy` is low makes channel i active exactly when mask bit i is 1. A start strobe while `busy` is high is ignored. `busy` is high while any channel is active.
- R5: Active channels are served in ascending index order, and each one finishes all its bytes before the next begins.
- R6: The peripheral address is the base plus an offset. The offset index starts at 0 per channel and wraps after 4 bytes. The offset patterns are:
  - modes 0, 2 and 6: 0,0,0,0
  - modes 1 and 5: 0,1,0,1
  - modes 3 and 7: 0,0,1,1
  - mode 4: 0,1,2,3
- R7: After each byte, the 16-bit memory offset is unchanged if the hold bit is set. Otherwise it decreases by one when the step-down bit is set and increases by one when that bit is clear, wrapping modulo 65536. The bank never changes.
- R8: The count decreases by one after each byte, and the channel stops when the count reaches 0. A starting count of 0 therefore moves 65536 bytes.
- R9: In the peripheral-to-memory direction, no memory write is issued in either of these cases:
  - the bank is 0x7E or 0x7F;
  - the bank is below 0x40 or within 0x80–0xBF, and the offset is below 0x2000.
- R10: In banks below 0x40 or within 0x80–0xBF, the offsets 0x420B, 0x420C, 0x4300–0x437F and 0x2100–0x21FF are illegal. At these offsets a memory write is dropped, and a memory read makes no request and yields `open_bus`.
- R11: A request stays high with a stable address, write flag and write data until its ready is seen. At most one of the two buses is requested at a time, and neither is requested while `busy` is low.
- R12: In the memory-to-peripheral direction, each byte is a memory read followed by a peripheral write of that data. In the other direction, each byte is a peripheral read followed by a memory write of that data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_sel | input | 7 | Channel (bits 6:4) and field (bits 3:0) select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` (combinational) |
| start_valid | input | 1 | Start strobe |
| start_mask | input | 8 | Channel enable mask for the start strobe |
| open_bus | input | 8 | Value taken by filtered memory reads |
| a_req | output | 1 | Memory bus request |
| a_we | output | 1 | Memory bus write flag |
| a_addr | output | 24 | Memory bus address {bank, offset} |
| a_wdata | output | 8 | Memory bus write data |
| a_rdata | input | 8 | Memory bus read data |
| a_ready | input | 1 | Memory bus completion |
| b_req | output | 1 | Peripheral bus request |
| b_we | output | 1 | Peripheral bus write flag |
| b_addr | output | 8 | Peripheral register address |
| b_wdata | output | 8 | Peripheral bus write data |
| b_rdata | input | 8 | Peripheral bus read data |
| b_ready | input | 1 | Peripheral bus completion |
| busy | output | 1 | High while any channel is active |

## Verification
The hardest property to reach from the ports is the counter wrap, where a zero count keeps a channel running through 65536 bytes. Running that whole transfer would cost far more cycles than the bench allows. Instead, the bench starts such a channel and lets 300 bytes complete. It then stops answering requests, which freezes the engine mid-transfer. With the engine frozen, the bench reads the count and offset registers and checks `busy`. A second hard case is a start strobe arriving mid-run. The bench issues one while another channel is transferring, then reads back the untouched channel's count and confirms that no unexpected bus transaction appeared.

// File: rtl/dma8_pkg.sv
package dma8_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_A_READ,
        ST_B_WRITE,
        ST_B_READ,
        ST_A_WRITE,
        ST_STEP
    } dma_state_t;

    typedef struct packed {
        logic       to_a;
        logic       indirect;
        logic       spare;
        logic       step_down;
        logic       hold;
        logic [2:0] mode;
    } ctrl_t;

    localparam logic [3:0] FLD_CTRL   = 4'd0;
    localparam logic [3:0] FLD_BANK   = 4'd1;
    localparam logic [3:0] FLD_ALO    = 4'd2;
    localparam logic [3:0] FLD_AHI    = 4'd3;
    localparam logic [3:0] FLD_CNTLO  = 4'd4;
    localparam logic [3:0] FLD_CNTHI  = 4'd5;
    localparam logic [3:0] FLD_BBASE  = 4'd6;
    localparam logic [3:0] FLD_XBANK  = 4'd7;
    localparam logic [3:0] FLD_TBLLO  = 4'd8;
    localparam logic [3:0] FLD_TBLHI  = 4'd9;
    localparam logic [3:0] FLD_LINE   = 4'd10;
    localparam logic [3:0] FLD_SPARE  = 4'd11;

    localparam logic [7:0] CTRL_RESET = 8'hF8;

    // Banks whose low half maps the shared system area.
    function automatic logic sys_bank(input logic [7:0] bank);
        return (bank < 8'h40) || ((bank >= 8'h80) && (bank < 8'hC0));
    endfunction

    // Memory-side targets that must never be touched by the engine.
    function automatic logic a_blocked(input logic [7:0] bank, input logic [15:0] ofs);
        return sys_bank(bank) &&
               ((ofs == 16'h420B) || (ofs == 16'h420C) ||
                (ofs[15:7] == 9'h086) || (ofs[15:8] == 8'h21));
    endfunction

    // Work-memory targets that a peripheral-to-memory move must not write.
    function automatic logic wram_target(input logic [7:0] bank, input logic [15:0] ofs);
        return (bank == 8'h7E) || (bank == 8'h7F) ||
               (sys_bank(bank) && (ofs < 16'h2000));
    endfunction

    function automatic logic [1:0] b_offset(input logic [2:0] mode, input logic [1:0] idx);
        logic [1:0] off;
        case (mode)
            3'd1, 3'd5: off = {1'b0, idx[0]};
            3'd3, 3'd7: off = {1'b0, idx[1]};
            3'd4:       off = idx;
            default:    off = 2'd0;
        endcase
        return off;
    endfunction

endpackage

// File: rtl/dma8_regfile.sv
module dma8_regfile
    import dma8_pkg::*;
#(
    parameter  int NUM_CH = 8,
    localparam int CHW    = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHW+3:0]    reg_sel,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              start_en,
    input  logic [NUM_CH-1:0] start_mask,
    input  logic [CHW-1:0]    sel_ch,
    input  logic              upd_en,
    input  logic [15:0]       upd_a_ofs,
    input  logic [15:0]       upd_count,
    input  logic              done_en,
    output logic [NUM_CH-1:0] active,
    output ctrl_t             sel_ctrl,
    output logic [7:0]        sel_bbase,
    output logic [7:0]        sel_bank,
    output logic [15:0]       sel_a_ofs,
    output logic [15:0]       sel_count
);

    ctrl_t       ctrl_q  [NUM_CH];
    logic [7:0]  bbase_q [NUM_CH];
    logic [7:0]  bank_q  [NUM_CH];
    logic [15:0] aofs_q  [NUM_CH];
    logic [15:0] count_q [NUM_CH];
    logic [7:0]  xbank_q [NUM_CH];
    logic [15:0] table_q [NUM_CH];
    logic [7:0]  line_q  [NUM_CH];
    logic [7:0]  spare_q [NUM_CH];
    logic [NUM_CH-1:0] active_q;

    logic [CHW-1:0] acc_ch;
    logic [3:0]     acc_fld;

    assign acc_ch  = reg_sel[CHW+3:4];
    assign acc_fld = reg_sel[3:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                ctrl_q[i]  <= ctrl_t'(CTRL_RESET);
                bbase_q[i] <= 8'hFF;
                bank_q[i]  <= 8'hFF;
                aofs_q[i]  <= 16'hFFFF;
                count_q[i] <= 16'hFFFF;
                xbank_q[i] <= 8'hFF;
                table_q[i] <= 16'hFFFF;
                line_q[i]  <= 8'hFF;
                spare_q[i] <= 8'hFF;
            end
            active_q <= '0;
        end else begin
            if (reg_wr) begin
                case (acc_fld)
                    FLD_CTRL:  ctrl_q[acc_ch]         <= ctrl_t'(reg_wdata);
                    FLD_BANK:  bank_q[acc_ch]         <= reg_wdata;
                    FLD_ALO:   aofs_q[acc_ch][7:0]    <= reg_wdata;
                    FLD_AHI:   aofs_q[acc_ch][15:8]   <= reg_wdata;
                    FLD_CNTLO: count_q[acc_ch][7:0]   <= reg_wdata;
                    FLD_CNTHI: count_q[acc_ch][15:8]  <= reg_wdata;
                    FLD_BBASE: bbase_q[acc_ch]        <= reg_wdata;
                    FLD_XBANK: xbank_q[acc_ch]        <= reg_wdata;
                    FLD_TBLLO: table_q[acc_ch][7:0]   <= reg_wdata;
                    FLD_TBLHI: table_q[acc_ch][15:8]  <= reg_wdata;
                    FLD_LINE:  line_q[acc_ch]         <= reg_wdata;
                    FLD_SPARE: spare_q[acc_ch]        <= reg_wdata;
                    default: ;
                endcase
            end
            if (upd_en) begin
                aofs_q[sel_ch]  <= upd_a_ofs;
                count_q[sel_ch] <= upd_count;
            end
            if (start_en) begin
                active_q <= start_mask;
            end
            if (done_en) begin
                active_q[sel_ch] <= 1'b0;
            end
        end
    end

    always_comb begin
        case (acc_fld)
            FLD_CTRL:  reg_rdata = ctrl_q[acc_ch];
            FLD_BANK:  reg_rdata = bank_q[acc_ch];
            FLD_ALO:   reg_rdata = aofs_q[acc_ch][7:0];
            FLD_AHI:   reg_rdata = aofs_q[acc_ch][15:8];
            FLD_CNTLO: reg_rdata = count_q[acc_ch][7:0];
            FLD_CNTHI: reg_rdata = count_q[acc_ch][15:8];
            FLD_BBASE: reg_rdata = bbase_q[acc_ch];
            FLD_XBANK: reg_rdata = xbank_q[acc_ch];
            FLD_TBLLO: reg_rdata = table_q[acc_ch][7:0];
            FLD_TBLHI: reg_rdata = table_q[acc_ch][15:8];
            FLD_LINE:  reg_rdata = line_q[acc_ch];
            FLD_SPARE: reg_rdata = spare_q[acc_ch];
            default:   reg_rdata = 8'hFF;
        endcase
    end

    assign active    = active_q;
    assign sel_ctrl  = ctrl_q[sel_ch];
    assign sel_bbase = bbase_q[sel_ch];
    assign sel_bank  = bank_q[sel_ch];
    assign sel_a_ofs = aofs_q[sel_ch];
    assign sel_count = count_q[sel_ch];

endmodule

// File: rtl/dma8_picker.sv
module dma8_picker #(
    parameter  int NUM_CH = 8,
    localparam int CHW    = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] active,
    output logic              any_active,
    output logic [CHW-1:0]    pick
);

    // Lowest set index wins: scan from the top so the last hit is the lowest.
    always_comb begin
        pick = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (active[i]) begin
                pick = CHW'(i);
            end
        end
    end

    assign any_active = |active;

endmodule

// File: rtl/dma8_guard.sv
module dma8_guard
    import dma8_pkg::*;
(
    input  logic [7:0]  bank,
    input  logic [15:0] ofs,
    output logic        rd_ok,
    output logic        wr_ok
);

    logic blocked;
    logic wram;

    assign blocked = a_blocked(bank, ofs);
    assign wram    = wram_target(bank, ofs);
    assign rd_ok   = !blocked;
    assign wr_ok   = !blocked && !wram;

endmodule

// File: rtl/dma8_engine.sv
module dma8_engine
    import dma8_pkg::*;
#(
    parameter  int NUM_CH = 8,
    localparam int CHW    = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHW+3:0]    reg_sel,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              start_valid,
    input  logic [NUM_CH-1:0] start_mask,
    input  logic [7:0]        open_bus,
    output logic              a_req,
    output logic              a_we,
    output logic [23:0]       a_addr,
    output logic [7:0]        a_wdata,
    input  logic [7:0]        a_rdata,
    input  logic              a_ready,
    output logic              b_req,
    output logic              b_we,
    output logic [7:0]        b_addr,
    output logic [7:0]        b_wdata,
    input  logic [7:0]        b_rdata,
    input  logic              b_ready,
    output logic              busy
);

    dma_state_t     state_q, state_d;
    logic [CHW-1:0] cur_q, cur_d;
    logic [1:0]     idx_q, idx_d;
    logic [7:0]     data_q, data_d;

    logic [NUM_CH-1:0] active;
    logic              any_active;
    logic [CHW-1:0]    pick;
    logic [CHW-1:0]    sel_ch;
    ctrl_t             sel_ctrl;
    logic [7:0]        sel_bbase;
    logic [7:0]        sel_bank;
    logic [15:0]       sel_a_ofs;
    logic [15:0]       sel_count;
    logic              rd_ok;
    logic              wr_ok;
    logic              start_en;
    logic              upd_en;
    logic              done_en;
    logic [15:0]       ofs_next;
    logic [15:0]       count_next;
    dma_state_t        first_phase;

    assign start_en = start_valid && !any_active;
    assign sel_ch   = (state_q == ST_IDLE) ? pick : cur_q;

    dma8_regfile #(.NUM_CH(NUM_CH)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_sel    (reg_sel),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .start_en   (start_en),
        .start_mask (start_mask),
        .sel_ch     (sel_ch),
        .upd_en     (upd_en),
        .upd_a_ofs  (ofs_next),
        .upd_count  (count_next),
        .done_en    (done_en),
        .active     (active),
        .sel_ctrl   (sel_ctrl),
        .sel_bbase  (sel_bbase),
        .sel_bank   (sel_bank),
        .sel_a_ofs  (sel_a_ofs),
        .sel_count  (sel_count)
    );

    dma8_picker #(.NUM_CH(NUM_CH)) u_pick (
        .active     (active),
        .any_active (any_active),
        .pick       (pick)
    );

    dma8_guard u_guard (
        .bank  (sel_bank),
        .ofs   (sel_a_ofs),
        .rd_ok (rd_ok),
        .wr_ok (wr_ok)
    );

    // Per-byte arithmetic on the selected channel.
    always_comb begin
        if (sel_ctrl.hold) begin
            ofs_next = sel_a_ofs;
        end else if (sel_ctrl.step_down) begin
            ofs_next = sel_a_ofs - 16'd1;
        end else begin
            ofs_next = sel_a_ofs + 16'd1;
        end
        count_next  = sel_count - 16'd1;
        first_phase = sel_ctrl.to_a ? ST_B_READ : ST_A_READ;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            idx_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            idx_q   <= idx_d;
            data_q  <= data_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        idx_d   = idx_q;
        data_d  = data_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_active) begin
                    cur_d   = pick;
                    idx_d   = 2'd0;
                    state_d = first_phase;
                end
            end
            ST_A_READ: begin
                if (!rd_ok) begin
                    data_d  = open_bus;
                    state_d = ST_B_WRITE;
                end else if (a_ready) begin
                    data_d  = a_rdata;
                    state_d = ST_B_WRITE;
                end
            end
            ST_B_WRITE: begin
                if (b_ready) begin
                    state_d = ST_STEP;
                end
            end
            ST_B_READ: begin
                if (b_ready) begin
                    data_d  = b_rdata;
                    state_d = ST_A_WRITE;
                end
            end
            ST_A_WRITE: begin
                if (!wr_ok || a_ready) begin
                    state_d = ST_STEP;
                end
            end
            ST_STEP: begin
                idx_d   = idx_q + 2'd1;
                state_d = (count_next == 16'd0) ? ST_IDLE : first_phase;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output logic.
    always_comb begin
        a_req   = 1'b0;
        a_we    = 1'b0;
        b_req   = 1'b0;
        b_we    = 1'b0;
        upd_en  = 1'b0;
        done_en = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_A_READ:  a_req = rd_ok;
            ST_B_WRITE: begin
                b_req = 1'b1;
                b_we  = 1'b1;
            end
            ST_B_READ:  b_req = 1'b1;
            ST_A_WRITE: begin
                a_req = wr_ok;
                a_we  = wr_ok;
            end
            ST_STEP: begin
                upd_en  = 1'b1;
                done_en = (count_next == 16'd0);
            end
            default: ;
        endcase
    end

    assign a_addr  = {sel_bank, sel_a_ofs};
    assign a_wdata = data_q;
    assign b_addr  = sel_bbase + {6'd0, b_offset(sel_ctrl.mode, idx_q)};
    assign b_wdata = data_q;
    assign busy    = any_active;

endmodule

// File: rtl/dma8_checker.sv
module dma8_checker
    import dma8_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        a_req,
    input logic        a_we,
    input logic [23:0] a_addr,
    input logic [7:0]  a_wdata,
    input logic        a_ready,
    input logic        b_req,
    input logic        b_we,
    input logic [7:0]  b_addr,
    input logic [7:0]  b_wdata,
    input logic        b_ready,
    input logic        busy
);

    a_r11_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && !a_ready) |=> (a_req && $stable(a_addr) && $stable(a_we) && $stable(a_wdata)));

    a_r11_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req && !b_ready) |=> (b_req && $stable(b_addr) && $stable(b_we) && $stable(b_wdata)));

    a_r11_one_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_req && b_req));

    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!a_req && !b_req));

    a_r10_no_blocked_access: assert property (@(posedge clk) disable iff (!rst_n)
        a_req |-> !a_blocked(a_addr[23:16], a_addr[15:0]));

    a_r9_no_wram_write: assert property (@(posedge clk) disable iff (!rst_n)
        (a_req && a_we) |-> !wram_target(a_addr[23:16], a_addr[15:0]));

endmodule

bind dma8_engine dma8_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_req   (a_req),
    .a_we    (a_we),
    .a_addr  (a_addr),
    .a_wdata (a_wdata),
    .a_ready (a_ready),
    .b_req   (b_req),
    .b_we    (b_we),
    .b_addr  (b_addr),
    .b_wdata (b_wdata),
    .b_ready (b_ready),
    .busy    (busy)
);

// File: tb/dma8_engine_bench.sv
`timescale 1ns/1ps
module dma8_engine_bench;

    localparam logic [7:0] OPEN = 8'hC3;

    typedef struct {
        bit    is_b;
        bit    we;
        int    addr;
        int    data;
        string tag;
    } txn_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        start_valid = 1'b0;
    logic [7:0]  start_mask = '0;
    logic        a_req, a_we, b_req, b_we, busy;
    logic [23:0] a_addr;
    logic [7:0]  a_wdata, b_addr, b_wdata;
    logic [7:0]  a_rdata = '0;
    logic [7:0]  b_rdata = '0;
    logic        a_ready = 1'b0;
    logic        b_ready = 1'b0;

    int   n_checks = 0;
    int   n_err = 0;
    txn_t expq[$];
    bit   track = 1'b1;
    bit   stall = 1'b0;
    int   a_wr_seen = 0;
    int   b_wr_seen = 0;
    int   a_wait = 0;
    int   b_wait = 0;
    int   dly = 0;

    int m_ctrl [8];
    int m_bbase[8];
    int m_bank [8];
    int m_aofs [8];
    int m_cnt  [8];

    always #2 clk = ~clk;

    dma8_engine u_dma8_engine (
        .clk(clk), .rst_n(rst_n),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .start_valid(start_valid), .start_mask(start_mask), .open_bus(OPEN),
        .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_ready(a_ready),
        .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_ready(b_ready),
        .busy(busy)
    );

    function automatic int amem(int a);
        return (a ^ (a >> 8) ^ (a >> 16) ^ 8'h5A) & 255;
    endfunction

    function automatic int bmem(int a);
        return (a * 3 + 1) & 255;
    endfunction

    function automatic bit sysb(int bank);
        return (bank < 'h40) || (bank >= 'h80 && bank < 'hC0);
    endfunction

    function automatic bit illegal(int bank, int ofs);
        return sysb(bank) && (ofs == 'h420B || ofs == 'h420C ||
               (ofs >= 'h4300 && ofs <= 'h437F) || (ofs >= 'h2100 && ofs <= 'h21FF));
    endfunction

    function automatic bit wram(int bank, int ofs);
        return bank == 'h7E || bank == 'h7F || (sysb(bank) && ofs < 'h2000);
    endfunction

    function automatic int offs(int mode, int k);
        case (mode)
            1, 5:    return k % 2;
            3, 7:    return (k / 2) % 2;
            4:       return k % 4;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic observe(input bit is_b, input bit we, input int addr, input int data);
        txn_t e;
        if (!track) return;
        if (expq.size() == 0) begin
            chk(0, "R4 unexpected transaction", addr, -1);
            return;
        end
        e = expq.pop_front();
        chk(e.is_b == is_b && e.we == we, {e.tag, " bus/kind"}, {is_b, we}, {e.is_b, e.we});
        chk(e.addr == addr, {e.tag, " address"}, addr, e.addr);
        if (we) chk(e.data == data, {e.tag, " write data"}, data, e.data);
    endtask

    // Bus responders: ready after a rotating delay, sampled away from the edge.
    always @(negedge clk) begin
        if (a_ready) begin
            a_ready = 1'b0;
            a_wait = 0;
        end else if (a_req && !stall) begin
            if (a_wait >= dly) begin
                a_rdata = 8'(amem(int'(a_addr)));
                if (a_we) a_wr_seen++;
                observe(1'b0, a_we, int'(a_addr), int'(a_wdata));
                a_ready = 1'b1;
                dly = (dly + 1) % 3;
            end else begin
                a_wait++;
            end
        end
        if (b_ready) begin
            b_ready = 1'b0;
            b_wait = 0;
        end else if (b_req && !stall) begin
            if (b_wait >= dly) begin
                b_rdata = 8'(bmem(int'(b_addr)));
                if (b_we) b_wr_seen++;
                observe(1'b1, b_we, int'(b_addr), int'(b_wdata));
                b_ready = 1'b1;
                dly = (dly + 2) % 3;
                if (!track && b_wr_seen >= 300) stall = 1'b1;
            end else begin
                b_wait++;
            end
        end
    end

    task automatic wr(input int ch, input int fld, input int val);
        @(negedge clk);
        reg_sel = 7'((ch << 4) | fld);
        reg_wdata = 8'(val);
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int ch, input int fld, output int val);
        @(negedge clk);
        reg_sel = 7'((ch << 4) | fld);
        #1 val = int'(reg_rdata);
    endtask

    task automatic rd_chk(input int ch, input int fld, input int exp, input string req);
        int v;
        rd(ch, fld, v);
        chk(v == exp, req, v, exp);
    endtask

    task automatic cfg(input int ch, input int ctrl, input int bbase, input int bank,
                       input int aofs, input int cnt);
        wr(ch, 0, ctrl);
        wr(ch, 6, bbase);
        wr(ch, 1, bank);
        wr(ch, 2, aofs & 255);
        wr(ch, 3, (aofs >> 8) & 255);
        wr(ch, 4, cnt & 255);
        wr(ch, 5, (cnt >> 8) & 255);
        m_ctrl[ch] = ctrl; m_bbase[ch] = bbase; m_bank[ch] = bank;
        m_aofs[ch] = aofs; m_cnt[ch] = cnt;
    endtask

    // Reference model: predicts every bus transaction of a started mask.
    task automatic model(input int mask);
        for (int ch = 0; ch < 8; ch++) begin
            if (mask[ch]) begin
                int n = (m_cnt[ch] == 0) ? 65536 : m_cnt[ch];
                int mode = m_ctrl[ch] & 7;
                for (int k = 0; k < n; k++) begin
                    int aa = (m_bank[ch] << 16) | m_aofs[ch];
                    int ba = (m_bbase[ch] + offs(mode, k)) & 255;
                    bit bad = illegal(m_bank[ch], m_aofs[ch]);
                    if (m_ctrl[ch][7] == 1'b0) begin
                        if (!bad) expq.push_back('{0, 0, aa, amem(aa), "R7/R12"});
                        expq.push_back('{1, 1, ba, bad ? int'(OPEN) : amem(aa),
                                         bad ? "R10" : "R6/R5"});
                    end else begin
                        expq.push_back('{1, 0, ba, bmem(ba), "R6/R12"});
                        if (!bad && !wram(m_bank[ch], m_aofs[ch]))
                            expq.push_back('{0, 1, aa, bmem(ba), "R9/R10"});
                    end
                    if (m_ctrl[ch][3] == 1'b0)
                        m_aofs[ch] = (m_ctrl[ch][4] ? m_aofs[ch] - 1 : m_aofs[ch] + 1) & 'hFFFF;
                end
                m_cnt[ch] = 0;
            end
        end
    endtask

    task automatic go(input int mask);
        @(negedge clk);
        start_mask = 8'(mask);
        start_valid = 1'b1;
        @(negedge clk);
        start_valid = 1'b0;
        #1 chk(busy == 1'b1, "R4 busy after start", busy, 1);
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(busy == 1'b0, "R8 run finished", busy, 0);
        chk(expq.size() == 0, "R5 all predicted transfers seen", expq.size(), 0);
    endtask

    task automatic final_chk(input int ch);
        rd_chk(ch, 2, m_aofs[ch] & 255, "R7 final offset low");
        rd_chk(ch, 3, (m_aofs[ch] >> 8) & 255, "R7 final offset high");
        rd_chk(ch, 4, 0, "R8 final count low");
        rd_chk(ch, 5, 0, "R8 final count high");
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk(busy == 1'b0, "R2 idle after reset", busy, 0);
        chk(a_req == 1'b0 && b_req == 1'b0, "R11 no request after reset", {a_req, b_req}, 0);

        // R2 reset values
        rd_chk(0, 0, 'hF8, "R2 ctrl reset");
        rd_chk(7, 6, 'hFF, "R2 base reset");
        rd_chk(3, 5, 'hFF, "R2 count high reset");
        rd_chk(5, 8, 'hFF, "R2 table low reset");
        rd_chk(2, 11, 'hFF, "R2 spare reset");

        // R1 field and channel decode, R3 control layout
        wr(2, 1, 'h12);
        wr(6, 1, 'h34);
        wr(4, 9, 'hA5);
        wr(4, 10, 'h3C);
        wr(1, 7, 'h66);
        rd_chk(2, 1, 'h12, "R1 ch2 bank");
        rd_chk(6, 1, 'h34, "R1 ch6 bank");
        rd_chk(4, 9, 'hA5, "R1 table high");
        rd_chk(4, 10, 'h3C, "R1 line counter");
        rd_chk(1, 7, 'h66, "R1 spare bank");
        rd_chk(1, 13, 'hFF, "R1 unused offset");
        wr(5, 0, 'h6B);
        rd_chk(5, 0, 'h6B, "R3 ctrl readback");

        // R12/R7: mode 0 increment, memory to peripheral
        cfg(0, 'h00, 'h18, 'h7E, 'h1000, 3);
        model('h01); go('h01); wait_idle(); final_chk(0);

        // R6/R7: mode 4, step down
        cfg(1, 'h14, 'h10, 'h00, 'h0105, 6);
        model('h02); go('h02); wait_idle(); final_chk(1);

        // R5: two channels, order 2 then 5; hold, mode 1; mode 7 wraps offset
        cfg(5, 'h09, 'h20, 'h7F, 'h8000, 3);
        cfg(2, 'h07, 'h30, 'hC0, 'hFFFE, 5);
        model('h24); go('h24); wait_idle(); final_chk(2); final_chk(5);

        // R9: peripheral to memory into guarded work-memory regions
        a_wr_seen = 0;
        cfg(4, 'h80, 'h40, 'h00, 'h1FFE, 4);
        cfg(7, 'h81, 'h50, 'h7E, 'h0000, 2);
        model('h90); go('h90); wait_idle(); final_chk(4); final_chk(7);
        chk(a_wr_seen == 2, "R9 memory writes issued", a_wr_seen, 2);

        // R10: illegal targets in both directions
        a_wr_seen = 0;
        cfg(0, 'h00, 'h60, 'h80, 'h420A, 3);
        cfg(1, 'h80, 'h70, 'h00, 'h437E, 3);
        cfg(3, 'h80, 'h71, 'h40, 'h2100, 1);
        model('h0B); go('h0B); wait_idle(); final_chk(0); final_chk(1); final_chk(3);
        chk(a_wr_seen == 2, "R10 memory writes issued", a_wr_seen, 2);

        // R4: start while busy is ignored
        cfg(0, 'h00, 'h08, 'h7E, 'h0200, 4);
        cfg(6, 'h00, 'h09, 'h7E, 'h0300, 2);
        model('h01); go('h01);
        go('h40);
        wait_idle();
        rd_chk(6, 4, 2, "R4 ignored channel count low");
        rd_chk(6, 5, 0, "R4 ignored channel count high");

        // R8: zero count keeps running past zero; freeze after 300 bytes
        cfg(3, 'h00, 'h02, 'h7E, 'h0000, 0);
        track = 1'b0;
        b_wr_seen = 0;
        go('h08);
        while (!stall) @(negedge clk);
        repeat (5) @(negedge clk);
        rd_chk(3, 4, 'hD4, "R8 wrapped count low");
        rd_chk(3, 5, 'hFE, "R8 wrapped count high");
        rd_chk(3, 2, 'h2C, "R7 offset after 300");
        rd_chk(3, 3, 'h01, "R7 offset high after 300");
        #1 chk(busy == 1'b1, "R8 still busy", busy, 1);

        summary();
        $finish;
    end

endmodule